// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the bit-level engine of an SPI master. It takes words from an external transmit FIFO and shifts them out most-significant bit first on a configurable data pin. At the same time it samples the input pin and hands each completed word to an external receive FIFO. A frame starts with a one-cycle `start` strobe. The engine latches the word length, the number of words and the target chip select, and keeps that chip select asserted until the last word has been stored.

Flow control follows the FIFO flags. By default a missing transmit word or a full receive FIFO pauses the transfer, with SCK parked low. When `noStall` is set the frame keeps running. An underrun then resends the previous word and an overrun drops the received word, and each event gives a one-cycle flag. The two data pins can be used as a split input/output pair in either direction, or one of them can be shared for both directions. What the output pin does while no chip select is asserted is also configurable.

Top module: `spim_shift_engine`

## Requirements
- R1: A `start` pulse while idle runs a frame of `frameWordsM1`+1 words of `wordBitsM1`+1 bits each, shifted MSB first. Each completed word appears on `rxData` with a one-cycle `rxPush` and equals the bits sampled during that word, in order.
- R2: SCK is low whenever `busy` is low. Each SCK high phase lasts exactly `clkDiv`+1 clock cycles and each low phase at least that long. Input is sampled in the last cycle of the high phase.
- R3: With `noStall`=0 and `txEmpty`=1 at the start of a word, the engine waits with SCK low and `busy` high, issues no `txPop`, and resumes once a word is available.
- R4: With `noStall`=0 and `rxFull`=1 at the end of a word, the engine waits with SCK low and issues no `rxPush` until `rxFull` falls.
- R5: With `noStall`=1 and `txEmpty`=1 at the start of a word, the previously sent word (zero after reset) is sent again and `underrunFlag` is high for exactly one cycle.
- R6: With `noStall`=1 and `rxFull`=1 at the end of a word, the received word is discarded (no `rxPush`), `overrunFlag` is high for one cycle, and the frame continues.
- R7: `pinMode` assigns data pin roles: 2'b00 input on pin A, output on pin B; 2'b01 pin A for both; 2'b10 pin B for both; 2'b11 input on pin B, output on pin A. The pin that is not the output never has its enable set.
- R8: In the shared modes (2'b01, 2'b10), during a frame the output enable is high only while SCK is low. The input is taken from that same pin.
- R9: Chip select line i is asserted (equal to `csPolarity[i]`) only while busy with `csSelect`=i latched. Every other line, and every line while idle, sits at `~csPolarity[i]`.
- R10: While idle, `idleTristate`=0 keeps the output pin enabled and holding the last bit shifted out. `idleTristate`=1 clears its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only while idle) |
| wordBitsM1 | input | 4 | Bits per word minus one |
| frameWordsM1 | input | 4 | Words per frame minus one |
| csSelect | input | 2 | Chip select used for the frame |
| clkDiv | input | 8 | SCK half period minus one, in clock cycles |
| noStall | input | 1 | Run through FIFO underrun/overrun instead of pausing |
| pinMode | input | 2 | Data pin role selection |
| csPolarity | input | 4 | Per-line active level (1 = active high) |
| idleTristate | input | 1 | Release output pin while idle |
| txEmpty | input | 1 | Transmit FIFO has no word |
| txData | input | 16 | Head word of the transmit FIFO |
| txPop | output | 1 | Consume the head transmit word |
| rxFull | input | 1 | Receive FIFO cannot accept a word |
| rxData | output | 16 | Received word, right aligned |
| rxPush | output | 1 | Write `rxData` into the receive FIFO |
| underrunFlag | output | 1 | One-cycle transmit underrun indication |
| overrunFlag | output | 1 | One-cycle receive overrun indication |
| busy | output | 1 | A frame is in progress |
| sck | output | 1 | Serial clock, idle low |
| csOut | output | 4 | Chip select lines |
| pinAOut | output | 1 | Data pin A output value |
| pinAOe | output | 1 | Data pin A output enable |
| pinAIn | input | 1 | Data pin A input value |
| pinBOut | output | 1 | Data pin B output value |
| pinBOe | output | 1 | Data pin B output enable |
| pinBIn | input | 1 | Data pin B input value |

## Verification
A wrong bit counter or alignment shift shows up at the first `rxPush` of a frame as a received word that differs from the one looped back, a word length plus a few cycles after the start. A divider fault shows within one SCK half period as a high phase of the wrong length. A stall fault shows as an SCK edge or a FIFO strobe during a window where the flags forbid one. Pin routing and enable faults show within one bit: either the looped-back data is lost or an enable is high while SCK is high in a shared mode.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_STORE,
    ST_FINISH
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadNew;
    logic loadLast;
    logic shiftBit;
    logic sampleBit;
  } dpStrobe_t;

  localparam logic [1:0] PIN_SPLIT   = 2'b00;
  localparam logic [1:0] PIN_SHARE_A = 2'b01;
  localparam logic [1:0] PIN_SHARE_B = 2'b10;
  localparam logic [1:0] PIN_SWAP    = 2'b11;

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int WCNT_W = 4,
  parameter int CS_N   = 4,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int CSEL_W = $clog2(CS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BIT_W-1:0]  bitLenIn,
  input  logic [WCNT_W-1:0] wordCntIn,
  input  logic [CSEL_W-1:0] csSelIn,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              noStall,
  input  logic              txEmpty,
  input  logic              rxFull,
  output dpStrobe_t         stb,
  output logic              txPop,
  output logic              rxPush,
  output logic              underrunPulse,
  output logic              overrunPulse,
  output logic              sck,
  output logic              active,
  output logic [BIT_W-1:0]  bitLen,
  output logic [CSEL_W-1:0] csSel
);

  ctrlState_e stateQ, stateD;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [BIT_W-1:0]  lenQ;
  logic [WCNT_W-1:0] wordIdx;
  logic [WCNT_W-1:0] wordTot;
  logic [CSEL_W-1:0] selQ;
  logic              sckQ;
  logic              activeQ;
  logic              divDone;
  logic              lastWord;

  assign divDone  = (divCnt == clkDiv);
  assign lastWord = (wordIdx == wordTot);

  always_comb begin
    stateD        = stateQ;
    stb           = '0;
    txPop         = 1'b0;
    rxPush        = 1'b0;
    underrunPulse = 1'b0;
    overrunPulse  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (start) stateD = ST_LOAD;
      end
      ST_LOAD: begin
        if (!txEmpty) begin
          txPop       = 1'b1;
          stb.loadNew = 1'b1;
          stateD      = ST_LOW;
        end else if (noStall) begin
          underrunPulse = 1'b1;
          stb.loadLast  = 1'b1;
          stateD        = ST_LOW;
        end
      end
      ST_LOW: begin
        if (divDone) stateD = ST_HIGH;
      end
      ST_HIGH: begin
        if (divDone) begin
          stb.sampleBit = 1'b1;
          if (bitIdx == '0) begin
            stateD = ST_STORE;
          end else begin
            stb.shiftBit = 1'b1;
            stateD       = ST_LOW;
          end
        end
      end
      ST_STORE: begin
        if (!rxFull) begin
          rxPush = 1'b1;
          stateD = lastWord ? ST_FINISH : ST_LOAD;
        end else if (noStall) begin
          overrunPulse = 1'b1;
          stateD       = lastWord ? ST_FINISH : ST_LOAD;
        end
      end
      ST_FINISH: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      divCnt  <= '0;
      bitIdx  <= '0;
      lenQ    <= '0;
      wordIdx <= '0;
      wordTot <= '0;
      selQ    <= '0;
      sckQ    <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      sckQ    <= (stateD == ST_HIGH);
      activeQ <= (stateD != ST_IDLE);
      if ((stateD != stateQ) || !((stateQ == ST_LOW) || (stateQ == ST_HIGH)))
        divCnt <= '0;
      else
        divCnt <= divCnt + 1'b1;
      if ((stateQ == ST_IDLE) && start) begin
        lenQ    <= bitLenIn;
        wordTot <= wordCntIn;
        selQ    <= csSelIn;
        wordIdx <= '0;
      end else if ((stateQ == ST_STORE) && (stateD == ST_LOAD)) begin
        wordIdx <= wordIdx + 1'b1;
      end
      if (stb.loadNew || stb.loadLast)
        bitIdx <= lenQ;
      else if (stb.shiftBit)
        bitIdx <= bitIdx - 1'b1;
    end
  end

  assign sck    = sckQ;
  assign active = activeQ;
  assign bitLen = lenQ;
  assign csSel  = selQ;

endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic [BIT_W-1:0]  bitLen,
  input  logic [DATA_W-1:0] txData,
  input  logic              inBit,
  output logic              outBit,
  output logic [DATA_W-1:0] rxData
);

  localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] lastWordQ;
  logic [DATA_W-1:0] txShiftQ;
  logic [DATA_W-1:0] rxShiftQ;
  logic              outBitQ;
  logic [BIT_W-1:0]  alignAmt;
  logic [DATA_W-1:0] srcWord;
  logic [DATA_W-1:0] aligned;

  // place the word's MSB at the top of the shifter
  always_comb begin
    alignAmt = TOP_IDX - bitLen;
    srcWord  = stb.loadNew ? txData : lastWordQ;
    aligned  = srcWord << alignAmt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastWordQ <= '0;
      txShiftQ  <= '0;
      rxShiftQ  <= '0;
      outBitQ   <= 1'b0;
    end else begin
      if (stb.loadNew) lastWordQ <= txData;
      if (stb.loadNew || stb.loadLast) begin
        txShiftQ <= aligned;
        outBitQ  <= aligned[DATA_W-1];
        rxShiftQ <= '0;
      end else begin
        if (stb.shiftBit) begin
          txShiftQ <= txShiftQ << 1;
          outBitQ  <= txShiftQ[DATA_W-2];
        end
        if (stb.sampleBit) rxShiftQ <= {rxShiftQ[DATA_W-2:0], inBit};
      end
    end
  end

  assign outBit = outBitQ;
  assign rxData = rxShiftQ;

endmodule

// File: rtl/spim_pinmux.sv
module spim_pinmux
  import spim_pkg::*;
(
  input  logic [1:0] pinMode,
  input  logic       active,
  input  logic       sck,
  input  logic       idleTristate,
  input  logic       outBit,
  input  logic       pinAIn,
  input  logic       pinBIn,
  output logic       pinAOut,
  output logic       pinAOe,
  output logic       pinBOut,
  output logic       pinBOe,
  output logic       inBit
);

  logic outOnA;
  logic inFromA;
  logic shared;
  logic drive;

  always_comb begin
    outOnA  = (pinMode == PIN_SHARE_A) || (pinMode == PIN_SWAP);
    inFromA = (pinMode == PIN_SPLIT) || (pinMode == PIN_SHARE_A);
    shared  = (pinMode == PIN_SHARE_A) || (pinMode == PIN_SHARE_B);
    if (active) drive = shared ? !sck : 1'b1;
    else        drive = !idleTristate;
    pinAOut = outBit;
    pinBOut = outBit;
    pinAOe  = drive && outOnA;
    pinBOe  = drive && !outOnA;
    inBit   = inFromA ? pinAIn : pinBIn;
  end

endmodule

// File: rtl/spim_csdrv.sv
module spim_csdrv #(
  parameter int CS_N = 4,
  localparam int CSEL_W = $clog2(CS_N)
) (
  input  logic              active,
  input  logic [CSEL_W-1:0] csSel,
  input  logic [CS_N-1:0]   csPolarity,
  output logic [CS_N-1:0]   csOut
);

  for (genvar i = 0; i < CS_N; i++) begin : g_line
    assign csOut[i] = (active && (csSel == CSEL_W'(i))) ? csPolarity[i] : !csPolarity[i];
  end

endmodule

// File: rtl/spim_shift_engine.sv
module spim_shift_engine
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int WCNT_W = 4,
  parameter int CS_N   = 4,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int CSEL_W = $clog2(CS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BIT_W-1:0]  wordBitsM1,
  input  logic [WCNT_W-1:0] frameWordsM1,
  input  logic [CSEL_W-1:0] csSelect,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              noStall,
  input  logic [1:0]        pinMode,
  input  logic [CS_N-1:0]   csPolarity,
  input  logic              idleTristate,
  input  logic              txEmpty,
  input  logic [DATA_W-1:0] txData,
  output logic              txPop,
  input  logic              rxFull,
  output logic [DATA_W-1:0] rxData,
  output logic              rxPush,
  output logic              underrunFlag,
  output logic              overrunFlag,
  output logic              busy,
  output logic              sck,
  output logic [CS_N-1:0]   csOut,
  output logic              pinAOut,
  output logic              pinAOe,
  input  logic              pinAIn,
  output logic              pinBOut,
  output logic              pinBOe,
  input  logic              pinBIn
);

  dpStrobe_t         stb;
  logic [BIT_W-1:0]  bitLen;
  logic [CSEL_W-1:0] csSel;
  logic              active;
  logic              sckInt;
  logic              outBit;
  logic              inBit;

  spim_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .WCNT_W(WCNT_W), .CS_N(CS_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bitLenIn(wordBitsM1),
    .wordCntIn(frameWordsM1), .csSelIn(csSelect), .clkDiv(clkDiv),
    .noStall(noStall), .txEmpty(txEmpty), .rxFull(rxFull), .stb(stb),
    .txPop(txPop), .rxPush(rxPush), .underrunPulse(underrunFlag),
    .overrunPulse(overrunFlag), .sck(sckInt), .active(active),
    .bitLen(bitLen), .csSel(csSel)
  );

  spim_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .bitLen(bitLen), .txData(txData),
    .inBit(inBit), .outBit(outBit), .rxData(rxData)
  );

  spim_pinmux u_pins (
    .pinMode(pinMode), .active(active), .sck(sckInt), .idleTristate(idleTristate),
    .outBit(outBit), .pinAIn(pinAIn), .pinBIn(pinBIn), .pinAOut(pinAOut),
    .pinAOe(pinAOe), .pinBOut(pinBOut), .pinBOe(pinBOe), .inBit(inBit)
  );

  spim_csdrv #(.CS_N(CS_N)) u_cs (
    .active(active), .csSel(csSel), .csPolarity(csPolarity), .csOut(csOut)
  );

  assign busy = active;
  assign sck  = sckInt;

endmodule

// File: rtl/spim_shift_engine_chk.sv
module spim_shift_engine_chk #(
  parameter int CS_N  = 4,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sck,
  input logic [CS_N-1:0]  csOut,
  input logic [CS_N-1:0]  csPolarity,
  input logic [1:0]       pinMode,
  input logic             pinAOe,
  input logic             pinBOe,
  input logic             underrunFlag,
  input logic             overrunFlag,
  input logic             rxPush,
  input logic             rxFull,
  input logic [DIV_W-1:0] clkDiv
);

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R2
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck) && (clkDiv != '0)) |=> sck);

  // R9
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(csOut ^ ~csPolarity) == 1));

  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csOut == ~csPolarity));

  // R8
  shared_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sck && ((pinMode == 2'b01) || (pinMode == 2'b10))) |-> !(pinAOe || pinBOe));

  // R7
  pin_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((pinMode == 2'b00 || pinMode == 2'b10) && pinAOe) && !((pinMode == 2'b01 || pinMode == 2'b11) && pinBOe));

  // R5
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrunFlag |=> !underrunFlag);

  // R6
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrunFlag |-> (!rxPush && rxFull));

  // R4
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxPush |-> !rxFull);

endmodule

bind spim_shift_engine spim_shift_engine_chk #(.CS_N(CS_N), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .csOut(csOut),
  .csPolarity(csPolarity), .pinMode(pinMode), .pinAOe(pinAOe), .pinBOe(pinBOe),
  .underrunFlag(underrunFlag), .overrunFlag(overrunFlag), .rxPush(rxPush),
  .rxFull(rxFull), .clkDiv(clkDiv)
);

// File: tb/spim_shift_engine_bench.sv
module spim_shift_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  wordBitsM1 = 4'd7;
  logic [3:0]  frameWordsM1 = 4'd0;
  logic [1:0]  csSelect = 2'd0;
  logic [7:0]  clkDiv = 8'd1;
  logic        noStall = 1'b0;
  logic [1:0]  pinMode = 2'b00;
  logic [3:0]  csPolarity = 4'b0101;
  logic        idleTristate = 1'b0;
  logic        txEmpty = 1'b1;
  logic [15:0] txData = '0;
  logic        txPop;
  logic        rxFull = 1'b0;
  logic [15:0] rxData;
  logic        rxPush;
  logic        underrunFlag, overrunFlag, busy, sck;
  logic [3:0]  csOut;
  logic        pinAOut, pinAOe, pinBOut, pinBOe;
  logic        pinAIn, pinBIn;

  always #5 clk = ~clk;

  spim_shift_engine u_spim_shift_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .wordBitsM1(wordBitsM1),
    .frameWordsM1(frameWordsM1), .csSelect(csSelect), .clkDiv(clkDiv),
    .noStall(noStall), .pinMode(pinMode), .csPolarity(csPolarity),
    .idleTristate(idleTristate), .txEmpty(txEmpty), .txData(txData), .txPop(txPop),
    .rxFull(rxFull), .rxData(rxData), .rxPush(rxPush), .underrunFlag(underrunFlag),
    .overrunFlag(overrunFlag), .busy(busy), .sck(sck), .csOut(csOut),
    .pinAOut(pinAOut), .pinAOe(pinAOe), .pinAIn(pinAIn), .pinBOut(pinBOut),
    .pinBOe(pinBOe), .pinBIn(pinBIn)
  );

  // slave model: one bit of a 32-bit pattern per SCK falling edge
  logic [31:0] slavePattern = '0;
  int          slaveFalls = 0;
  int          slaveBase = 0;
  int          slaveIdx;
  logic        slaveBit;
  always @(negedge sck) slaveFalls <= slaveFalls + 1;
  assign slaveIdx = slaveFalls - slaveBase;
  assign slaveBit = slavePattern[5'(31 - slaveIdx)];

  // pads: a driven pad carries its value; an input-only pad sees the other pad
  assign pinAIn = pinAOe ? pinAOut : (pinBOe ? pinBOut : slaveBit);
  assign pinBIn = pinBOe ? pinBOut : (pinAOe ? pinAOut : slaveBit);

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // transmit FIFO model and scoreboard queues
  logic [15:0] txQ[$];
  logic [15:0] expQ[$];
  logic        popSeen = 1'b0;
  always @(posedge clk) popSeen <= txPop;

  int rxCount = 0, urunCycles = 0, orunCycles = 0, riseCount = 0;
  int oeViol = 0, divViol = 0, highRun = 0;
  logic sckPrev = 1'b0;

  always @(negedge clk) begin
    if (popSeen && (txQ.size() > 0)) void'(txQ.pop_front());
    txEmpty = (txQ.size() == 0);
    txData  = (txQ.size() > 0) ? txQ[0] : 16'h0;
    // monitor
    if (sck && !sckPrev) riseCount++;
    if (sck) highRun++;
    else if (highRun != 0) begin
      if (highRun != int'(clkDiv) + 1) divViol++;
      highRun = 0;
    end
    sckPrev = sck;
    if (underrunFlag) urunCycles++;
    if (overrunFlag) orunCycles++;
    if (busy && sck && (pinMode == 2'b01 || pinMode == 2'b10) && (pinAOe || pinBOe)) oeViol++;
    if ((pinMode == 2'b01 && pinBOe) || (pinMode == 2'b10 && pinAOe)) oeViol++;
    if (rxPush) begin
      rxCount++;
      if (expQ.size() == 0) check(1'b0, "R1 unexpected word", 32'(rxData), 32'h0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check(rxData == e, "R1 received word", 32'(rxData), 32'(e));
      end
    end
  end

  task automatic driveWord(input logic [15:0] w, input bit expectBack);
    txQ.push_back(w);
    if (expectBack) expQ.push_back(w);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    check(1'b0, "R1 frame did not end", 32'(busy), 32'h0);
  endtask

  task automatic startFrame(input logic [1:0] sel, input logic [3:0] words, input logic [3:0] bits);
    logic [3:0] expCs;
    repeat (2) @(negedge clk);
    csSelect = sel; frameWordsM1 = words; wordBitsM1 = bits;
    slaveBase = slaveFalls;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) expCs[i] = (i == int'(sel)) ? csPolarity[i] : ~csPolarity[i];
    check(csOut == expCs, "R9 chip select during frame", 32'(csOut), 32'(expCs));
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(!busy && !sck, "R2 reset idle", {30'h0, busy, sck}, 32'h0);
    check(csOut == 4'b1010, "R9 reset chip selects", 32'(csOut), 32'hA);

    // R1 R7: split mode 00 loopback, 3 byte words
    pinMode = 2'b00; clkDiv = 8'd1;
    driveWord(16'h00A5, 1); driveWord(16'h003C, 1); driveWord(16'h00F0, 1);
    startFrame(2'd2, 4'd2, 4'd7);
    waitIdle();
    check(expQ.size() == 0, "R1 all words received (mode 00)", 32'(expQ.size()), 32'h0);
    check(divViol == 0, "R2 high phase length div1", 32'(divViol), 32'h0);
    check(csOut == 4'b1010, "R9 chip selects released", 32'(csOut), 32'hA);

    // R7: swapped mode 11 loopback, 16-bit words, fastest SCK
    pinMode = 2'b11; clkDiv = 8'd0;
    driveWord(16'hBEEF, 1); driveWord(16'h1234, 1);
    startFrame(2'd0, 4'd1, 4'd15);
    waitIdle();
    check(expQ.size() == 0, "R7 words received (mode 11)", 32'(expQ.size()), 32'h0);
    check(divViol == 0, "R2 high phase length div0", 32'(divViol), 32'h0);

    // R8: shared on pin A, slave supplies data
    pinMode = 2'b01; clkDiv = 8'd2;
    slavePattern = {8'h96, 8'h4D, 16'h0};
    driveWord(16'h0011, 0); driveWord(16'h0022, 0);
    expQ.push_back(16'h0096); expQ.push_back(16'h004D);
    startFrame(2'd3, 4'd1, 4'd7);
    waitIdle();
    check(expQ.size() == 0, "R8 shared pin A input", 32'(expQ.size()), 32'h0);
    check(oeViol == 0, "R8 enable only while SCK low (A)", 32'(oeViol), 32'h0);

    // R8: shared on pin B
    pinMode = 2'b10; clkDiv = 8'd1;
    slavePattern = {8'h5C, 24'h0};
    driveWord(16'h00FF, 0);
    expQ.push_back(16'h005C);
    startFrame(2'd1, 4'd0, 4'd7);
    waitIdle();
    check(expQ.size() == 0, "R8 shared pin B input", 32'(expQ.size()), 32'h0);
    check(oeViol == 0, "R8 enable only while SCK low (B)", 32'(oeViol), 32'h0);

    // R3: stall on empty transmit FIFO
    pinMode = 2'b00; clkDiv = 8'd0;
    driveWord(16'h00C3, 1);
    base = rxCount;
    startFrame(2'd0, 4'd1, 4'd7);
    for (int i = 0; i < 2000 && rxCount == base; i++) @(negedge clk);
    base = riseCount;
    repeat (30) @(negedge clk);
    check(riseCount == base, "R3 no SCK edge while empty", 32'(riseCount), 32'(base));
    check(busy && !sck, "R3 busy with SCK low during stall", {30'h0, busy, sck}, 32'h2);
    driveWord(16'h007E, 1);
    waitIdle();
    check(expQ.size() == 0, "R3 resumed after data arrived", 32'(expQ.size()), 32'h0);

    // R4: stall on full receive FIFO
    rxFull = 1'b1;
    driveWord(16'h0099, 1);
    base = riseCount;
    startFrame(2'd0, 4'd0, 4'd7);
    for (int i = 0; i < 2000 && riseCount < base + 8; i++) @(negedge clk);
    base = rxCount;
    repeat (20) @(negedge clk);
    check(rxCount == base, "R4 no push while full", 32'(rxCount), 32'(base));
    check(busy && !sck, "R4 busy with SCK low during stall", {30'h0, busy, sck}, 32'h2);
    rxFull = 1'b0;
    waitIdle();
    check(rxCount == base + 1, "R4 word pushed after release", 32'(rxCount), 32'(base + 1));

    // R5: underrun without stall resends last word
    noStall = 1'b1;
    driveWord(16'h005A, 1);
    expQ.push_back(16'h005A);
    base = urunCycles;
    startFrame(2'd1, 4'd1, 4'd7);
    waitIdle();
    check(expQ.size() == 0, "R5 repeated word received", 32'(expQ.size()), 32'h0);
    check(urunCycles == base + 1, "R5 one-cycle underrun flag", 32'(urunCycles - base), 32'h1);

    // R6: overrun without stall drops words
    rxFull = 1'b1;
    driveWord(16'h0011, 0); driveWord(16'h0022, 0);
    base = orunCycles;
    begin
      int rb;
      rb = rxCount;
      startFrame(2'd2, 4'd1, 4'd7);
      waitIdle();
      check(rxCount == rb, "R6 no word pushed", 32'(rxCount), 32'(rb));
    end
    check(orunCycles == base + 2, "R6 one overrun cycle per word", 32'(orunCycles - base), 32'h2);
    rxFull = 1'b0; noStall = 1'b0;

    // R10: idle output behaviour
    idleTristate = 1'b0;
    driveWord(16'h0081, 1);
    startFrame(2'd0, 4'd0, 4'd7);
    waitIdle();
    @(negedge clk);
    check(pinBOe && pinBOut, "R10 hold last bit 1", {30'h0, pinBOe, pinBOut}, 32'h3);
    driveWord(16'h0080, 1);
    startFrame(2'd0, 4'd0, 4'd7);
    waitIdle();
    @(negedge clk);
    check(pinBOe && !pinBOut, "R10 hold last bit 0", {30'h0, pinBOe, pinBOut}, 32'h2);
    idleTristate = 1'b1;
    @(negedge clk);
    check(!pinBOe && !pinAOe, "R10 tristate while idle", {30'h0, pinAOe, pinBOe}, 32'h0);
    check(expQ.size() == 0, "R1 scoreboard drained", 32'(expQ.size()), 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule